// File: doc/BRIEF.md
# Line-Addressed FIFO Write Controller

This block is the write-side control for a field memory that is organised as lines of words and filled in FIFO order. It holds the current line number and a column pointer that walks through the words of that line. From a small set of control inputs, all sampled on the rising write clock, it produces a registered write strobe, byte enables and a line/column address for an external storage array. It also raises a one-cycle commit strobe that tells the array to move the staged line into its cells.

A cycle with the reset/transfer input high is a line control cycle. In that cycle the shared enable/zero input clears the line number, or the increment input advances it. When neither is set, the cycle only commits the line. Outside control cycles, the same shared input acts as an address enable. While it is held high, a 10-bit line number arrives one bit per clock on a serial pin, most significant bit first, and the top bit is dropped. Lowering the write enable while both byte enables are active skips a word: the column advances but nothing is written, which lets an inset picture leave the surrounding pixels untouched. A block-mode input freezes all of this behaviour while another agent owns the memory.

Top module: `lfifo_wr_ctrl`

## Requirements
- R1: After reset, or after a reset in the middle of a run, `cur_line_o` is 0, `arr_we_o`, `arr_be_o` and `commit_o` are 0, and the next write uses column 0.
- R2: In a control cycle (`ctl_rst_xfer_i`=1, `mode_blk_i`=0) with `ctl_aen_zero_i`=1, `cur_line_o` becomes 0 after that edge, whatever `ctl_line_inc_i` is.
- R3: In a control cycle with `ctl_line_inc_i`=1 and `ctl_aen_zero_i`=0, `cur_line_o` becomes its previous value plus one, modulo 2^LINE_AW (511 wraps to 0).
- R4: Every control cycle sets `commit_o`=1 for one cycle after the edge, with `commit_line_o` equal to the line number held before the edge. It performs no array write and returns the column pointer to 0.
- R5: Outside control cycles, each cycle with `ctl_aen_zero_i`=1 shifts `ser_addr_i` into the loader, MSB first. On the edge of the 10th consecutive bit, `cur_line_o` takes the last 9 bits received, so the first bit (bit 9) is discarded.
- R6: If the enable drops after fewer than 10 bits, or a cycle without shifting occurs, the line number is unchanged. The next load starts counting again from bit 9.
- R7: Outside control cycles, with `wr_enable_i`=1 and at least one active-low bit of `byte_wr_n_i` at 0, the output after the edge shows: `arr_we_o`=1, `arr_be_o` equal to the inverse of `byte_wr_n_i`, `arr_line_o` equal to the current line and `arr_col_o` equal to the column pointer. The pointer then advances by one.
- R8: With `wr_enable_i`=0 and all bits of `byte_wr_n_i` at 0, no write occurs but the pointer advances. With `wr_enable_i`=0 and only some bytes active, or `wr_enable_i`=1 and no byte active, neither happens.
- R9: The column pointer counts from 0 to LINE_WORDS-1 and then wraps to 0.
- R10: While `mode_blk_i`=1, every other control input is ignored. No write or commit occurs, and the line number, the column pointer and a partly shifted serial address all hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Write clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_blk_i | input | 1 | Block mode: ignore all FIFO controls |
| ctl_rst_xfer_i | input | 1 | High marks a line control (reset/commit) cycle |
| ctl_line_inc_i | input | 1 | Increment line in a control cycle |
| ctl_aen_zero_i | input | 1 | Zero line in a control cycle; serial address enable otherwise |
| ser_addr_i | input | 1 | Serial line address bit, MSB first |
| wr_enable_i | input | 1 | Write enable; low masks writes |
| byte_wr_n_i | input | NUM_BYTES | Active-low byte write enables |
| cur_line_o | output | LINE_AW | Current line number |
| arr_we_o | output | 1 | Array write strobe |
| arr_be_o | output | NUM_BYTES | Array byte enables, active high |
| arr_line_o | output | LINE_AW | Line address of the write |
| arr_col_o | output | COL_W | Column address of the write |
| commit_o | output | 1 | One-cycle line commit strobe |
| commit_line_o | output | LINE_AW | Line being committed |

## Verification
The bound checker watches every cycle for the effect of a control cycle on the line number and the commit strobe, for the byte enables and address of a write, for the absence of a write when writing is masked or block mode is set, and for a line number that holds when no load or control cycle occurs. Only the bench scenarios can show the column sequence: skipped words, partial-byte cases and the wrap at the end of a line. The same holds for serial loads, where the 10-bit count, the dropped top bit, the restart after an aborted shift and a shift that resumes across block mode all depend on history longer than a simple property can follow.

// File: rtl/lfifo_wr_pkg.sv
package lfifo_wr_pkg;

    // Per-cycle operation chosen by the decoder
    typedef enum logic [2:0] {
        OP_NONE      = 3'd0,
        OP_LINE_ZERO = 3'd1,
        OP_LINE_INC  = 3'd2,
        OP_COMMIT    = 3'd3,
        OP_WRITE     = 3'd4,
        OP_SKIP      = 3'd5
    } wr_op_e;

    function automatic logic is_ctrl_op(input wr_op_e op);
        return (op == OP_LINE_ZERO) || (op == OP_LINE_INC) || (op == OP_COMMIT);
    endfunction

endpackage

// File: rtl/lfifo_wr_decode.sv
module lfifo_wr_decode
    import lfifo_wr_pkg::*;
#(
    parameter int NUM_BYTES = 2
) (
    input  logic                 mode_blk_i,
    input  logic                 rst_xfer_i,
    input  logic                 line_inc_i,
    input  logic                 aen_zero_i,
    input  logic                 wr_enable_i,
    input  logic [NUM_BYTES-1:0] byte_wr_n_i,
    output wr_op_e               op_o,
    output logic                 shift_o,
    output logic                 hold_o
);

    localparam logic [NUM_BYTES-1:0] ALL_OFF = {NUM_BYTES{1'b1}};
    localparam logic [NUM_BYTES-1:0] ALL_ON  = {NUM_BYTES{1'b0}};

    always_comb begin
        op_o    = OP_NONE;
        shift_o = 1'b0;
        hold_o  = mode_blk_i;
        if (!mode_blk_i) begin
            if (rst_xfer_i) begin
                // zeroing has priority over incrementing
                if (aen_zero_i) begin
                    op_o = OP_LINE_ZERO;
                end else if (line_inc_i) begin
                    op_o = OP_LINE_INC;
                end else begin
                    op_o = OP_COMMIT;
                end
            end else begin
                shift_o = aen_zero_i;
                if (wr_enable_i && (byte_wr_n_i != ALL_OFF)) begin
                    op_o = OP_WRITE;
                end else if (!wr_enable_i && (byte_wr_n_i == ALL_ON)) begin
                    op_o = OP_SKIP;
                end
            end
        end
    end

endmodule

// File: rtl/lfifo_wr_serial_load.sv
module lfifo_wr_serial_load #(
    parameter int ADDR_BITS = 10,
    parameter int LINE_AW   = 9
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               shift_i,
    input  logic               hold_i,
    input  logic               bit_i,
    output logic               fire_o,
    output logic [LINE_AW-1:0] word_o
);

    localparam int CNT_W = $clog2(ADDR_BITS + 1);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ADDR_BITS - 1);

    typedef struct packed {
        logic [ADDR_BITS-2:0] sh;
        logic [CNT_W-1:0]     cnt;
    } ld_s;

    ld_s ld_d, ld_q;
    logic [ADDR_BITS-1:0] full;

    always_comb begin
        full   = {ld_q.sh, bit_i};
        fire_o = shift_i && (ld_q.cnt == LAST_IDX);
        word_o = full[LINE_AW-1:0];
        ld_d   = ld_q;
        if (hold_i) begin
            ld_d = ld_q;
        end else if (shift_i) begin
            ld_d.sh  = full[ADDR_BITS-2:0];
            ld_d.cnt = fire_o ? '0 : ld_q.cnt + 1'b1;
        end else begin
            ld_d.cnt = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ld_q <= '0;
        end else begin
            ld_q <= ld_d;
        end
    end

endmodule

// File: rtl/lfifo_wr_col_ptr.sv
module lfifo_wr_col_ptr #(
    parameter int LINE_WORDS = 960
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          clr_i,
    input  logic                          adv_i,
    output logic [$clog2(LINE_WORDS)-1:0] col_o
);

    localparam int COL_W = $clog2(LINE_WORDS);
    localparam logic [COL_W-1:0] LAST_COL = COL_W'(LINE_WORDS - 1);
    localparam bit   POW2 = ((LINE_WORDS & (LINE_WORDS - 1)) == 0);

    logic [COL_W-1:0] col_d, col_q, col_inc;

    generate
        if (POW2) begin : g_wrap_free
            assign col_inc = col_q + 1'b1;
        end else begin : g_wrap_cmp
            assign col_inc = (col_q == LAST_COL) ? '0 : col_q + 1'b1;
        end
    endgenerate

    always_comb begin
        col_d = col_q;
        if (clr_i) begin
            col_d = '0;
        end else if (adv_i) begin
            col_d = col_inc;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            col_q <= '0;
        end else begin
            col_q <= col_d;
        end
    end

    assign col_o = col_q;

endmodule

// File: rtl/lfifo_wr_ctrl.sv
module lfifo_wr_ctrl
    import lfifo_wr_pkg::*;
#(
    parameter int LINE_AW    = 9,
    parameter int ADDR_BITS  = 10,
    parameter int LINE_WORDS = 960,
    parameter int NUM_BYTES  = 2,
    localparam int COL_W     = $clog2(LINE_WORDS)
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 mode_blk_i,
    input  logic                 ctl_rst_xfer_i,
    input  logic                 ctl_line_inc_i,
    input  logic                 ctl_aen_zero_i,
    input  logic                 ser_addr_i,
    input  logic                 wr_enable_i,
    input  logic [NUM_BYTES-1:0] byte_wr_n_i,
    output logic [LINE_AW-1:0]   cur_line_o,
    output logic                 arr_we_o,
    output logic [NUM_BYTES-1:0] arr_be_o,
    output logic [LINE_AW-1:0]   arr_line_o,
    output logic [COL_W-1:0]     arr_col_o,
    output logic                 commit_o,
    output logic [LINE_AW-1:0]   commit_line_o
);

    typedef struct packed {
        logic [LINE_AW-1:0]   line;
        logic                 we;
        logic [NUM_BYTES-1:0] be;
        logic [LINE_AW-1:0]   aline;
        logic [COL_W-1:0]     acol;
        logic                 commit;
        logic [LINE_AW-1:0]   cline;
    } ctl_s;

    ctl_s st_d, st_q;

    wr_op_e             op;
    logic               shift_en;
    logic               hold;
    logic               load_fire;
    logic [LINE_AW-1:0] load_word;
    logic [COL_W-1:0]   col;
    logic               col_clr;
    logic               col_adv;

    lfifo_wr_decode #(
        .NUM_BYTES (NUM_BYTES)
    ) u_decode (
        .mode_blk_i  (mode_blk_i),
        .rst_xfer_i  (ctl_rst_xfer_i),
        .line_inc_i  (ctl_line_inc_i),
        .aen_zero_i  (ctl_aen_zero_i),
        .wr_enable_i (wr_enable_i),
        .byte_wr_n_i (byte_wr_n_i),
        .op_o        (op),
        .shift_o     (shift_en),
        .hold_o      (hold)
    );

    lfifo_wr_serial_load #(
        .ADDR_BITS (ADDR_BITS),
        .LINE_AW   (LINE_AW)
    ) u_load (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .shift_i (shift_en),
        .hold_i  (hold),
        .bit_i   (ser_addr_i),
        .fire_o  (load_fire),
        .word_o  (load_word)
    );

    assign col_clr = is_ctrl_op(op);
    assign col_adv = (op == OP_WRITE) || (op == OP_SKIP);

    lfifo_wr_col_ptr #(
        .LINE_WORDS (LINE_WORDS)
    ) u_col (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (col_clr),
        .adv_i  (col_adv),
        .col_o  (col)
    );

    always_comb begin
        st_d        = st_q;
        st_d.we     = 1'b0;
        st_d.be     = '0;
        st_d.commit = 1'b0;
        unique case (op)
            OP_LINE_ZERO: st_d.line = '0;
            OP_LINE_INC:  st_d.line = st_q.line + 1'b1;
            OP_WRITE: begin
                st_d.we    = 1'b1;
                st_d.be    = ~byte_wr_n_i;
                st_d.aline = st_q.line;
                st_d.acol  = col;
            end
            default: ;
        endcase
        if (is_ctrl_op(op)) begin
            st_d.commit = 1'b1;
            st_d.cline  = st_q.line;
        end
        if (load_fire) begin
            st_d.line = load_word;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_line_o    = st_q.line;
    assign arr_we_o      = st_q.we;
    assign arr_be_o      = st_q.be;
    assign arr_line_o    = st_q.aline;
    assign arr_col_o     = st_q.acol;
    assign commit_o      = st_q.commit;
    assign commit_line_o = st_q.cline;

endmodule

// File: rtl/lfifo_wr_ctrl_chk.sv
module lfifo_wr_ctrl_chk #(
    parameter int LINE_AW    = 9,
    parameter int LINE_WORDS = 960,
    parameter int NUM_BYTES  = 2,
    parameter int COL_W      = $clog2(LINE_WORDS)
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic                 mode_blk_i,
    input logic                 ctl_rst_xfer_i,
    input logic                 ctl_line_inc_i,
    input logic                 ctl_aen_zero_i,
    input logic                 wr_enable_i,
    input logic [NUM_BYTES-1:0] byte_wr_n_i,
    input logic [LINE_AW-1:0]   cur_line_o,
    input logic                 arr_we_o,
    input logic [NUM_BYTES-1:0] arr_be_o,
    input logic [LINE_AW-1:0]   arr_line_o,
    input logic [COL_W-1:0]     arr_col_o,
    input logic                 commit_o,
    input logic [LINE_AW-1:0]   commit_line_o
);

    localparam logic [NUM_BYTES-1:0] ALL_OFF = {NUM_BYTES{1'b1}};
    localparam logic [COL_W-1:0] LAST_COL = COL_W'(LINE_WORDS - 1);

    AST_ZERO_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!mode_blk_i && ctl_rst_xfer_i && ctl_aen_zero_i) |=> (cur_line_o == '0)); // R2

    AST_LINE_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!mode_blk_i && ctl_rst_xfer_i && ctl_line_inc_i && !ctl_aen_zero_i)
        |=> (cur_line_o == LINE_AW'($past(cur_line_o) + 1'b1))); // R3

    AST_COMMIT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!mode_blk_i && ctl_rst_xfer_i)
        |=> (commit_o && !arr_we_o && (commit_line_o == $past(cur_line_o)))); // R4

    AST_WRITE_FIELDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!mode_blk_i && !ctl_rst_xfer_i && wr_enable_i && (byte_wr_n_i != ALL_OFF))
        |=> (arr_we_o && (arr_be_o == ~$past(byte_wr_n_i)) && (arr_line_o == $past(cur_line_o)))); // R7

    AST_WE_HAS_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        arr_we_o |-> (arr_be_o != '0)); // R7

    AST_MASKED_NO_WE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!wr_enable_i) |=> !arr_we_o); // R8

    AST_COL_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        arr_we_o |-> (arr_col_o <= LAST_COL)); // R9

    AST_LINE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!mode_blk_i && !ctl_rst_xfer_i && !ctl_aen_zero_i) |=> $stable(cur_line_o)); // R6

    AST_BLK_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mode_blk_i |=> (!arr_we_o && !commit_o && $stable(cur_line_o))); // R10

endmodule

bind lfifo_wr_ctrl lfifo_wr_ctrl_chk #(
    .LINE_AW    (LINE_AW),
    .LINE_WORDS (LINE_WORDS),
    .NUM_BYTES  (NUM_BYTES),
    .COL_W      (COL_W)
) u_chk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .mode_blk_i     (mode_blk_i),
    .ctl_rst_xfer_i (ctl_rst_xfer_i),
    .ctl_line_inc_i (ctl_line_inc_i),
    .ctl_aen_zero_i (ctl_aen_zero_i),
    .wr_enable_i    (wr_enable_i),
    .byte_wr_n_i    (byte_wr_n_i),
    .cur_line_o     (cur_line_o),
    .arr_we_o       (arr_we_o),
    .arr_be_o       (arr_be_o),
    .arr_line_o     (arr_line_o),
    .arr_col_o      (arr_col_o),
    .commit_o       (commit_o),
    .commit_line_o  (commit_line_o)
);

// File: tb/lfifo_wr_ctrl_tb.sv
`timescale 1ns/1ps
module lfifo_wr_ctrl_tb;

    localparam int LAW   = 9;
    localparam int WORDS = 6;
    localparam int CW    = $clog2(WORDS);
    localparam int NV    = 18;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           blk = 1'b0, rx = 1'b0, inc = 1'b0, aen = 1'b0, ser = 1'b0, en = 1'b0;
    logic [1:0]     bwn = 2'b11;
    logic [LAW-1:0] line, aline, cline;
    logic           we, commit;
    logic [1:0]     be;
    logic [CW-1:0]  acol;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    lfifo_wr_ctrl #(
        .LINE_AW    (LAW),
        .ADDR_BITS  (10),
        .LINE_WORDS (WORDS),
        .NUM_BYTES  (2)
    ) u_dut (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .mode_blk_i     (blk),
        .ctl_rst_xfer_i (rx),
        .ctl_line_inc_i (inc),
        .ctl_aen_zero_i (aen),
        .ser_addr_i     (ser),
        .wr_enable_i    (en),
        .byte_wr_n_i    (bwn),
        .cur_line_o     (line),
        .arr_we_o       (we),
        .arr_be_o       (be),
        .arr_line_o     (aline),
        .arr_col_o      (acol),
        .commit_o       (commit),
        .commit_line_o  (cline)
    );

    // stim {blk,rx,inc,aen,ser,en,bwn[1:0]} | line | we | be | wline | wcol | commit | cline
    localparam logic [41:0] VEC [NV] = '{
        {8'b00000100, 9'd0, 1'b1, 2'b11, 9'd0, 3'd0, 1'b0, 9'd0}, // R7 both bytes, col 0
        {8'b00000110, 9'd0, 1'b1, 2'b01, 9'd0, 3'd1, 1'b0, 9'd0}, // R7 low byte only
        {8'b00000000, 9'd0, 1'b0, 2'b00, 9'd0, 3'd0, 1'b0, 9'd0}, // R8 masked skip
        {8'b00000001, 9'd0, 1'b0, 2'b00, 9'd0, 3'd0, 1'b0, 9'd0}, // R8 masked, partial bytes
        {8'b00000111, 9'd0, 1'b0, 2'b00, 9'd0, 3'd0, 1'b0, 9'd0}, // R8 enabled, no bytes
        {8'b00000101, 9'd0, 1'b1, 2'b10, 9'd0, 3'd3, 1'b0, 9'd0}, // R8 skip moved col to 3
        {8'b00000100, 9'd0, 1'b1, 2'b11, 9'd0, 3'd4, 1'b0, 9'd0}, // R7
        {8'b00000100, 9'd0, 1'b1, 2'b11, 9'd0, 3'd5, 1'b0, 9'd0}, // R9 last column
        {8'b00000100, 9'd0, 1'b1, 2'b11, 9'd0, 3'd0, 1'b0, 9'd0}, // R9 wrapped
        {8'b01100100, 9'd1, 1'b0, 2'b00, 9'd0, 3'd0, 1'b1, 9'd0}, // R3 R4 inc
        {8'b01100100, 9'd2, 1'b0, 2'b00, 9'd0, 3'd0, 1'b1, 9'd1}, // R3 R4 inc
        {8'b00000100, 9'd2, 1'b1, 2'b11, 9'd2, 3'd0, 1'b0, 9'd0}, // R4 col back to 0
        {8'b01000100, 9'd2, 1'b0, 2'b00, 9'd0, 3'd0, 1'b1, 9'd2}, // R4 commit only
        {8'b00000100, 9'd2, 1'b1, 2'b11, 9'd2, 3'd0, 1'b0, 9'd0}, // R4
        {8'b01110100, 9'd0, 1'b0, 2'b00, 9'd0, 3'd0, 1'b1, 9'd2}, // R2 zero beats inc
        {8'b11100100, 9'd0, 1'b0, 2'b00, 9'd0, 3'd0, 1'b0, 9'd0}, // R10 ctrl ignored
        {8'b10000100, 9'd0, 1'b0, 2'b00, 9'd0, 3'd0, 1'b0, 9'd0}, // R10 write ignored
        {8'b00000100, 9'd0, 1'b1, 2'b11, 9'd0, 3'd0, 1'b0, 9'd0}  // R10 col held
    };

    function automatic string vec_tag(input int i);
        case (i)
            0, 1, 6:      return "R7";
            2, 3, 4, 5:   return "R8";
            7, 8:         return "R9";
            9, 10:        return "R3";
            11, 12, 13:   return "R4";
            14:           return "R2";
            default:      return "R10";
        endcase
    endfunction

    task automatic drive(input logic b, input logic r, input logic i, input logic a,
                         input logic s, input logic e, input logic [1:0] bw);
        blk = b; rx = r; inc = i; aen = a; ser = s; en = e; bwn = bw;
        @(posedge clk);
        #1;
    endtask

    task automatic chk_line(input logic [LAW-1:0] exp, input string tag);
        checks++;
        if (line !== exp) begin
            fails++;
            $display("FAIL %s: line actual %0d expected %0d", tag, line, exp);
        end
    endtask

    task automatic shift_bits(input logic [9:0] v, input int n, input int msb);
        for (int k = 0; k < n; k++) begin
            drive(1'b0, 1'b0, 1'b0, 1'b1, v[msb - k], 1'b0, 2'b11);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R1 reset state
        checks++;
        if (line !== 9'd0 || we !== 1'b0 || be !== 2'b00 || commit !== 1'b0) begin
            fails++;
            $display("FAIL R1: line/we/be/commit actual %0d/%b/%b/%b expected 0/0/00/0",
                     line, we, be, commit);
        end

        for (int i = 0; i < NV; i++) begin
            logic [41:0] v;
            bit bad;
            v = VEC[i];
            drive(v[41], v[40], v[39], v[38], v[37], v[36], v[35:34]);
            bad = (line !== v[33:25]) || (we !== v[24]) || (commit !== v[9]);
            if (v[24]) bad = bad || (be !== v[23:22]) || (aline !== v[21:13]) || (acol !== v[12:10]);
            if (v[9])  bad = bad || (cline !== v[8:0]);
            checks++;
            if (bad) begin
                fails++;
                $display("FAIL %s vector %0d: actual line%0d we%b be%b wl%0d wc%0d c%b cl%0d expected line%0d we%b be%b wl%0d wc%0d c%b cl%0d",
                         vec_tag(i), i, line, we, be, aline, acol, commit, cline,
                         v[33:25], v[24], v[23:22], v[21:13], v[12:10], v[9], v[8:0]);
            end
        end

        // R5 serial load, first bit discarded: 10'b1011010101 -> 213
        shift_bits(10'b1011010101, 9, 9);
        chk_line(9'd0, "R6 nine bits only");
        shift_bits(10'b1011010101, 1, 0);
        chk_line(9'd213, "R5 ten bits loaded");

        // R6 aborted shift then restart
        shift_bits(10'b1111100000, 5, 9);
        drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'b11);
        chk_line(9'd213, "R6 abort keeps line");
        shift_bits(10'b0111111111, 9, 9);
        chk_line(9'd213, "R6 restart counts ten");
        shift_bits(10'b0111111111, 1, 0);
        chk_line(9'd511, "R5 second load");

        // R3 wrap 511 -> 0, R4 commit carries old line
        drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'b11);
        chk_line(9'd0, "R3 wrap");
        checks++;
        if (commit !== 1'b1 || cline !== 9'd511) begin
            fails++;
            $display("FAIL R4: commit/line actual %b/%0d expected 1/511", commit, cline);
        end

        // R10 partial shift held across block mode
        shift_bits(10'b0000000101, 4, 9);
        for (int k = 0; k < 3; k++) drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 2'b00);
        chk_line(9'd0, "R10 line held");
        checks++;
        if (commit !== 1'b0 || we !== 1'b0) begin
            fails++;
            $display("FAIL R10: commit/we actual %b/%b expected 0/0", commit, we);
        end
        shift_bits(10'b0000000101, 6, 5);
        chk_line(9'd5, "R10 shift resumed");

        // R2 zero from nonzero
        drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'b11);
        chk_line(9'd0, "R2 zero");

        // move pointer and line, then R1 mid-run reset
        drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'b11);
        drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'b00);
        drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'b00);
        rst_n = 1'b0;
        drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b11);
        checks++;
        if (line !== 9'd0 || we !== 1'b0 || commit !== 1'b0) begin
            fails++;
            $display("FAIL R1: mid-run reset line/we/commit actual %0d/%b/%b expected 0/0/0",
                     line, we, commit);
        end
        rst_n = 1'b1;
        drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'b00);
        checks++;
        if (we !== 1'b1 || acol !== 3'd0 || aline !== 9'd0) begin
            fails++;
            $display("FAIL R1: write after reset we/col/line actual %b/%0d/%0d expected 1/0/0",
                     we, acol, aline);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule